// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. Seven instructions are implemented: unsigned add and subtract between registers, OR with a zero-extended immediate, word load, word store, branch when two registers are equal, and an absolute jump. Each instruction is 32 bits wide, and the core decodes its fields straight into control points. Those control points steer a register file with two read ports, an immediate extender, an ALU and a word-addressed data memory. The program counter, the register file and the data memory all update on the same rising edge.

The program sits in an internal instruction memory, which is filled through a write port. Loading is normally done while reset is held. The core exposes a debug view of the current program counter and of the register write that will commit at the next edge.

The next-PC choice has three named kinds. `NPC_SEQ` moves on to the following word. `NPC_BRANCH` is taken when a compare-equal succeeds. `NPC_JUMP` is taken for the absolute jump. Transitions between them are decided afresh in every cycle from the fetched instruction. Decoding first classifies each instruction into one of eight kinds:

- `K_ADDU`
- `K_SUBU`
- `K_ORI`
- `K_LW`
- `K_SW`
- `K_BEQ`
- `K_J`
- `K_NOP`

The control points are then produced from that kind.

Top module: `sc_core`

## Requirements
- R1: An instruction whose next-PC kind is sequential sets the PC to PC+4, and the instruction memory is indexed by PC bits [IMEM_AW+1:2]. Fields are op [31:26], rs [25:21], rt [20:16], rd [15:11] and immediate [15:0].
- R2: With op 000000, funct 100001 writes R[rs]+R[rt] into R[rd] and funct 100011 writes R[rs]-R[rt] into R[rd], both modulo 2^32.
- R3: Op 001101 writes R[rs] OR the zero-extended immediate into R[rt].
- R4: Op 100011 reads the data word at address R[rs]+sign-extended immediate, indexed by address bits [DMEM_AW+1:2], and writes it into R[rt].
- R5: Op 101011 writes R[rt] to the data word at R[rs]+sign-extended immediate, and writes no register.
- R6: Op 000100 sets the next PC to PC+4+(sign-extended immediate × 4) when R[rs]==R[rt], and to PC+4 otherwise. It writes no register.
- R7: Op 000010 sets the next PC to {(PC+4)[31:28], instruction[25:0], 00}.
- R8: Register 0 always reads as zero, and writes aimed at it are discarded.
- R9: Any other op value, or op 000000 with any other funct, writes neither register nor memory and advances the PC by 4.
- R10: A synchronous reset sets the PC to 0 and blocks register and memory writes while it is held. Register and memory contents survive the reset.
- R11: dbg_pc shows the current PC. dbg_wr_en, dbg_wr_addr and dbg_wr_data show the register write that commits at the next edge, and dbg_wr_en is 0 for writes aimed at register 0.
- R12: A value written at an edge is the value seen by the very next instruction, whether the value went to a register or to the data memory.
- R13: When prog_we is 1, prog_data is written into instruction-memory word prog_addr at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Instruction-memory write enable |
| prog_addr | input | IMEM_AW | Instruction-memory word index to write |
| prog_data | input | 32 | Instruction word to write |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | A register write commits at the next edge |
| dbg_wr_addr | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
The core runs in lockstep with a behavioural model in the bench, and the PC and the committed register write are compared in every cycle.

A long random program exercises the main function. It mixes all seven instructions with unrecognised encodings, and roughly half of its compares use the same register twice so that taken branches occur often. Because random base registers and offsets spread loads and stores across the whole data array, a wrong address sum or a stray store shows up as a later load mismatch.

A directed program covers the following corners:
- zero extension of 0xFFFF;
- subtract wrap-around;
- store followed at once by a load;
- a negative load offset;
- a write to register 0 followed by a read of it;
- a not-taken branch against a taken one;
- a jump;
- a backward branch.

A reset in the middle of a run shows that only the PC returns to 0 and that the stored state is kept.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_ORI   = 6'b001101;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_J     = 6'b000010;

    localparam logic [5:0] FN_ADDU  = 6'b100001;
    localparam logic [5:0] FN_SUBU  = 6'b100011;

    typedef enum logic [2:0] {
        K_NOP, K_ADDU, K_SUBU, K_ORI, K_LW, K_SW, K_BEQ, K_J
    } kind_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_OR
    } alu_op_e;

    typedef enum logic [1:0] {
        NPC_SEQ, NPC_BRANCH, NPC_JUMP
    } npc_e;

    typedef struct packed {
        logic    dst_rd;    // destination: 1 = rd field, 0 = rt field
        logic    alu_imm;   // ALU operand B from the extender
        logic    ext_sign;  // extender mode: 1 = sign, 0 = zero
        alu_op_e alu_op;
        logic    mem_wr;
        logic    wb_mem;    // write-back from data memory
        logic    reg_wr;
        logic    branch;
        logic    jump;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output kind_e      kind,
    output ctrl_t      ctrl
);

    // classify the instruction
    always_comb begin
        kind = K_NOP;
        unique case (op)
            OP_RTYPE: begin
                if (funct == FN_ADDU)      kind = K_ADDU;
                else if (funct == FN_SUBU) kind = K_SUBU;
                else                       kind = K_NOP;
            end
            OP_ORI:  kind = K_ORI;
            OP_LW:   kind = K_LW;
            OP_SW:   kind = K_SW;
            OP_BEQ:  kind = K_BEQ;
            OP_J:    kind = K_J;
            default: kind = K_NOP;
        endcase
    end

    // control points per kind
    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (kind)
            K_ADDU: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_wr = 1'b1;
                ctrl.alu_op = ALU_ADD;
            end
            K_SUBU: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_wr = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            K_ORI: begin
                ctrl.alu_imm = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            K_LW: begin
                ctrl.alu_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.wb_mem   = 1'b1;
                ctrl.reg_wr   = 1'b1;
            end
            K_SW: begin
                ctrl.alu_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            K_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            K_J: begin
                ctrl.jump = 1'b1;
            end
            K_NOP: begin
                ctrl = '0;
            end
        endcase
    end

endmodule

// File: rtl/sc_fetch.sv
module sc_fetch
    import sc_pkg::*;
#(
    parameter int IMEM_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_we,
    input  logic [IMEM_AW-1:0] prog_addr,
    input  logic [31:0]        prog_data,
    input  logic               branch,
    input  logic               jump,
    input  logic               equal,
    output logic [31:0]        pc,
    output logic [31:0]        instr
);

    localparam int IMEM_WORDS = 1 << IMEM_AW;

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] pc_plus4;
    logic [31:0] br_off;
    logic [31:0] pc_next;
    npc_e        npc_kind;

    always_ff @(posedge clk) begin
        if (prog_we) imem[prog_addr] <= prog_data;
    end

    assign instr    = imem[pc[IMEM_AW+1:2]];
    assign pc_plus4 = pc + 32'd4;
    assign br_off   = {{14{instr[15]}}, instr[15:0], 2'b00};

    always_comb begin
        if (jump)                 npc_kind = NPC_JUMP;
        else if (branch && equal) npc_kind = NPC_BRANCH;
        else                      npc_kind = NPC_SEQ;
    end

    always_comb begin
        unique case (npc_kind)
            NPC_SEQ:    pc_next = pc_plus4;
            NPC_BRANCH: pc_next = pc_plus4 + br_off;
            NPC_JUMP:   pc_next = {pc_plus4[31:28], instr[25:0], 2'b00};
            default:    pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    // R10
    pc_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pc == 32'd0);

    // R1
    pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (npc_kind == NPC_SEQ) |=> pc == $past(pc) + 32'd4);

    // R6
    pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (npc_kind == NPC_BRANCH) |=>
            pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

    // R7
    pc_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (npc_kind == NPC_JUMP) |=> (pc[1:0] == 2'b00) && (pc[27:2] == $past(instr[25:0])));

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int REG_AW = 5,
    parameter int XLEN   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] ra,
    input  logic [REG_AW-1:0] rb,
    output logic [XLEN-1:0]   rdata_a,
    output logic [XLEN-1:0]   rdata_b,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [XLEN-1:0]   wdata
);

    localparam int NREGS = 1 << REG_AW;

    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) regs[waddr] <= wdata;
    end

    assign rdata_a = (ra == '0) ? '0 : regs[ra];
    assign rdata_b = (rb == '0) ? '0 : regs[rb];

    // R8
    r0_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> waddr != '0);

    // R12
    rf_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr == ra) && $stable(ra)) |=> ($stable(ra) -> rdata_a == $past(wdata)));

endmodule

// File: rtl/sc_exec.sv
module sc_exec
    import sc_pkg::*;
#(
    parameter int DMEM_AW = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] opa,
    input  logic [31:0] opb,
    input  logic [15:0] imm,
    input  logic        ext_sign,
    input  logic        alu_imm,
    input  alu_op_e     alu_op,
    input  logic        mem_we,
    input  logic        wb_mem,
    output logic        equal,
    output logic [31:0] wb_data
);

    localparam int DMEM_WORDS = 1 << DMEM_AW;

    logic [31:0] ext_imm;
    logic [31:0] alu_b;
    logic [31:0] alu_y;
    logic [31:0] dmem [DMEM_WORDS];
    logic [31:0] load_data;
    logic [DMEM_AW-1:0] widx;

    assign ext_imm = ext_sign ? {{16{imm[15]}}, imm} : {16'h0000, imm};
    assign alu_b   = alu_imm ? ext_imm : opb;

    always_comb begin
        unique case (alu_op)
            ALU_ADD: alu_y = opa + alu_b;
            ALU_SUB: alu_y = opa - alu_b;
            ALU_OR:  alu_y = opa | alu_b;
            default: alu_y = opa + alu_b;
        endcase
    end

    assign equal     = (opa == opb);
    assign widx      = alu_y[DMEM_AW+1:2];
    assign load_data = dmem[widx];
    assign wb_data   = wb_mem ? load_data : alu_y;

    always_ff @(posedge clk) begin
        if (mem_we) dmem[widx] <= opb;
    end

    // R10
    no_store_in_reset_chk: assert property (@(posedge clk)
        rst |-> !mem_we);

    // R12
    store_load_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && wb_mem) |-> 1'b0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_AW = 8,
    parameter int DMEM_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_we,
    input  logic [IMEM_AW-1:0] prog_addr,
    input  logic [31:0]        prog_data,
    output logic [31:0]        dbg_pc,
    output logic               dbg_wr_en,
    output logic [4:0]         dbg_wr_addr,
    output logic [31:0]        dbg_wr_data
);

    logic [31:0] pc;
    logic [31:0] instr;
    kind_e       kind;
    ctrl_t       ctrl;
    logic [31:0] rdata_a;
    logic [31:0] rdata_b;
    logic        equal;
    logic [31:0] wb_data;
    logic [4:0]  waddr;
    logic        rf_we;
    logic        mem_we;

    sc_fetch #(.IMEM_AW(IMEM_AW)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .branch    (ctrl.branch),
        .jump      (ctrl.jump),
        .equal     (equal),
        .pc        (pc),
        .instr     (instr)
    );

    sc_decode u_decode (
        .op    (instr[31:26]),
        .funct (instr[5:0]),
        .kind  (kind),
        .ctrl  (ctrl)
    );

    assign waddr  = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign rf_we  = ctrl.reg_wr && !rst && (waddr != 5'd0);
    assign mem_we = ctrl.mem_wr && !rst;

    sc_regfile #(.REG_AW(5), .XLEN(32)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra      (instr[25:21]),
        .rb      (instr[20:16]),
        .rdata_a (rdata_a),
        .rdata_b (rdata_b),
        .we      (rf_we),
        .waddr   (waddr),
        .wdata   (wb_data)
    );

    sc_exec #(.DMEM_AW(DMEM_AW)) u_exec (
        .clk      (clk),
        .rst      (rst),
        .opa      (rdata_a),
        .opb      (rdata_b),
        .imm      (instr[15:0]),
        .ext_sign (ctrl.ext_sign),
        .alu_imm  (ctrl.alu_imm),
        .alu_op   (ctrl.alu_op),
        .mem_we   (mem_we),
        .wb_mem   (ctrl.wb_mem),
        .equal    (equal),
        .wb_data  (wb_data)
    );

    assign dbg_pc      = pc;
    assign dbg_wr_en   = rf_we;
    assign dbg_wr_addr = waddr;
    assign dbg_wr_data = wb_data;

    // R9
    unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == K_NOP) |-> !dbg_wr_en && !mem_we);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> !dbg_wr_en);

    // R5
    store_no_regwr_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OP_SW) |-> !dbg_wr_en);

    // R8
    r0_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_wr_en |-> dbg_wr_addr != 5'd0);

endmodule

// File: tb/sc_core_test.sv
module sc_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int IMEM_AW    = 8;
    localparam int DMEM_AW    = 6;
    localparam int IWORDS     = 1 << IMEM_AW;
    localparam int DWORDS     = 1 << DMEM_AW;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               prog_we = 1'b0;
    logic [IMEM_AW-1:0] prog_addr = '0;
    logic [31:0]        prog_data = '0;
    logic [31:0]        dbg_pc;
    logic               dbg_wr_en;
    logic [4:0]         dbg_wr_addr;
    logic [31:0]        dbg_wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] prog [IWORDS];
    logic [31:0] m_rf [32];
    logic [31:0] m_dm [DWORDS];
    logic [31:0] m_pc;
    string       phase;

    sc_core #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) uut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
        .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] tgt);
        return {6'b000010, tgt};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
        end
    endtask

    task automatic load_program();
        for (int i = 0; i < IWORDS; i++) begin
            @(negedge clk);
            prog_we   = 1'b1;
            prog_addr = i[IMEM_AW-1:0];
            prog_data = prog[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    // Model one cycle: compare at mid-cycle, then apply the register transfer.
    task automatic step();
        logic [31:0] ins, a, b, sx, zx, addr, npc, wd;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd, wa;
        logic        wr, st;
        string       tag;
        ins = prog[m_pc[IMEM_AW+1:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        a  = m_rf[rs]; b = m_rf[rt];
        sx = {{16{ins[15]}}, ins[15:0]};
        zx = {16'h0000, ins[15:0]};
        npc = m_pc + 32'd4;
        wr = 1'b0; st = 1'b0; wa = 5'd0; wd = 32'd0; addr = 32'd0;
        tag = "R9";
        if (op == 6'b000000 && fn == 6'b100001) begin
            wr = 1'b1; wa = rd; wd = a + b; tag = "R2";
        end else if (op == 6'b000000 && fn == 6'b100011) begin
            wr = 1'b1; wa = rd; wd = a - b; tag = "R2";
        end else if (op == 6'b001101) begin
            wr = 1'b1; wa = rt; wd = a | zx; tag = "R3";
        end else if (op == 6'b100011) begin
            addr = a + sx; wr = 1'b1; wa = rt; wd = m_dm[addr[DMEM_AW+1:2]]; tag = "R4";
        end else if (op == 6'b101011) begin
            addr = a + sx; st = 1'b1; tag = "R5";
        end else if (op == 6'b000100) begin
            if (a == b) npc = m_pc + 32'd4 + (sx << 2);
            tag = "R6";
        end else if (op == 6'b000010) begin
            npc = {npc[31:28], ins[25:0], 2'b00}; tag = "R7";
        end
        if (wr && wa == 5'd0) begin
            wr = 1'b0; tag = "R8";
        end
        check("R1 pc", dbg_pc, m_pc);
        check({tag, " R11 wr_en"}, {31'd0, dbg_wr_en}, {31'd0, wr});
        if (wr) begin
            check({tag, " R11 wr_addr"}, {27'd0, dbg_wr_addr}, {27'd0, wa});
            check({tag, " R12 wr_data"}, dbg_wr_data, wd);
            m_rf[wa] = wd;
        end
        if (st) m_dm[addr[DMEM_AW+1:2]] = b;
        m_pc = npc;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            step();
            @(negedge clk);
            #1;
        end
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst = 1'b0;
        m_pc = 32'd0;
        #1;
    endtask

    function automatic logic [31:0] rand_instr();
        int unsigned k;
        logic [4:0] rs, rt, rd;
        logic [15:0] imm;
        k  = $urandom % 10;
        rs = 5'($urandom); rt = 5'($urandom); rd = 5'($urandom);
        imm = 16'($urandom);
        case (k)
            0: return enc_r(rs, rt, rd, 6'b100001);
            1: return enc_r(rs, rt, rd, 6'b100011);
            2: return enc_i(6'b001101, rs, rt, imm);
            3: return enc_i(6'b100011, rs, rt, imm);
            4: return enc_i(6'b101011, rs, rt, imm);
            5: return enc_i(6'b000100, rs, (($urandom % 2) == 0) ? rs : rt,
                            16'($signed(5'($urandom))));
            6: return enc_j(26'($urandom % IWORDS));
            7: return enc_r(rs, rt, rd, 6'b100000);
            8: return enc_i(6'b111111, rs, rt, imm);
            default: return enc_r(rs, rt, rd, 6'b100001);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5eed));
        for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
        for (int i = 0; i < DWORDS; i++) m_dm[i] = 32'd0;

        // Program 1: initialise state, then a random mix (R13 load path).
        for (int i = 0; i < 31; i++)
            prog[i] = enc_i(6'b001101, 5'd0, 5'(i + 1), 16'($urandom));
        for (int i = 0; i < DWORDS; i++)
            prog[31 + i] = enc_i(6'b101011, 5'd0, 5'((i % 31) + 1), 16'(i * 4));
        for (int i = 31 + DWORDS; i < IWORDS; i++)
            prog[i] = rand_instr();

        phase = "R10 reset";
        load_program();
        @(negedge clk);
        #1;
        check("R10 pc in reset", dbg_pc, 32'd0);
        check("R10 no write in reset", {31'd0, dbg_wr_en}, 32'd0);

        phase = "R13 init";
        release_reset();
        run(31 + DWORDS);
        phase = "R13 random";
        run(4000);

        // Reset mid-run: PC returns to 0, stored state kept.
        phase = "R10 mid-run";
        @(negedge clk);
        rst = 1'b1;
        #1;
        check("R10 write blocked", {31'd0, dbg_wr_en}, 32'd0);
        @(negedge clk);
        #1;
        check("R10 pc cleared", dbg_pc, 32'd0);
        release_reset();
        run(300);

        // Program 2: directed corners.
        for (int i = 0; i < IWORDS; i++) prog[i] = 32'd0;
        prog[0]  = enc_i(6'b001101, 5'd0, 5'd1, 16'hFFFF);
        prog[1]  = enc_r(5'd1, 5'd1, 5'd2, 6'b100001);
        prog[2]  = enc_r(5'd0, 5'd1, 5'd3, 6'b100011);
        prog[3]  = enc_i(6'b101011, 5'd0, 5'd3, 16'd8);
        prog[4]  = enc_i(6'b100011, 5'd0, 5'd4, 16'd8);
        prog[5]  = enc_i(6'b001101, 5'd1, 5'd0, 16'd5);
        prog[6]  = enc_r(5'd0, 5'd0, 5'd5, 6'b100001);
        prog[7]  = enc_i(6'b001101, 5'd0, 5'd6, 16'h0040);
        prog[8]  = enc_i(6'b100011, 5'd6, 5'd7, 16'hFFFC);
        prog[9]  = enc_i(6'b111111, 5'd1, 5'd9, 16'h1234);
        prog[10] = enc_r(5'd1, 5'd2, 5'd10, 6'b100000);
        prog[11] = enc_i(6'b000100, 5'd1, 5'd2, 16'd5);
        prog[12] = enc_i(6'b000100, 5'd4, 5'd3, 16'd2);
        prog[13] = enc_i(6'b001101, 5'd0, 5'd8, 16'd1);
        prog[14] = enc_i(6'b001101, 5'd0, 5'd9, 16'd2);
        prog[15] = enc_j(26'd18);
        prog[16] = enc_i(6'b001101, 5'd0, 5'd11, 16'd3);
        prog[17] = enc_i(6'b001101, 5'd0, 5'd12, 16'd4);
        prog[18] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFED);
        phase = "R10 reload";
        @(negedge clk);
        rst = 1'b1;
        load_program();
        phase = "R12 directed";
        release_reset();
        run(60);

        // Spot checks of the directed results through the write view.
        check("R3 zero-extended 0xFFFF", m_rf[1], 32'h0000FFFF);
        check("R2 subtract wraps", m_rf[3], 32'hFFFF0001);
        check("R12 store then load", m_rf[4], 32'hFFFF0001);
        check("R8 r0 reads zero", m_rf[5], 32'd0);
        check("R6 taken branch skipped r8", m_rf[8] == 32'd1 ? 32'd1 : 32'd0, 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule